// File: doc/BRIEF.md
# DDR SDRAM Start-Up Command Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-on to a usable state. Reset holds the clock enable low and the command bus at no-operation. Once the board reports that supplies and clock are stable, the block waits out the required 200 µs settling time. It converts that time into clock cycles from a clock-frequency parameter. Then it raises the clock enable and issues the fixed start-up command list.

The list is:

1. a precharge of all banks,
2. a write of the extended mode register that leaves the DLL enabled,
3. a write of the main mode register with the DLL-reset bit set,
4. a second precharge of all banks,
5. two auto refreshes,
6. a final write of the main mode register with the DLL-reset bit cleared.

A parameterized gap follows each command: `T_RP` after a precharge, `T_MRD` after a mode-register write and `T_RFC` after a refresh. Separately, a guard counts `DLL_CYC` cycles from the DLL-reset command. The ready flag is held back until both the final gap and that count have run out. The ready flag is what allows the controller to start issuing reads.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, on every clock edge the outputs become: `cke` 0, command NOP, `bank_sel` 0, `addr` 0, `init_done` 0.
- R2: `cke` rises, with a NOP on the bus, at the clock edge that samples `pwr_stable` high for the `PWRUP_CYC = CLK_MHZ*PWRUP_US`-th consecutive time. A low sample restarts the count. Once `cke` is high it stays high until reset.
- R3: The command is `{cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}`. Its codes are NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001 and MODE REGISTER SET 0000. Every cycle without a command carries NOP. No command other than NOP appears while `cke` is low.
- R4: Exactly seven commands are issued, in this order: PRECHARGE, MRS, MRS, PRECHARGE, REFRESH, REFRESH, MRS. The first PRECHARGE comes one cycle after `cke` rises.
- R5: The next command follows exactly `T_RP` cycles after a PRECHARGE, `T_MRD` cycles after an MRS and `T_RFC` cycles after a REFRESH.
- R6: A PRECHARGE drives `addr` with only bit 10 set and `bank_sel` 00. A REFRESH drives `addr` 0 and `bank_sel` 00.
- R7: The first MRS targets the extended register: `bank_sel` 01, `addr` 0 (DLL enabled).
- R8: The second MRS targets the main register: `bank_sel` 00, `addr` = `mode_val` with bit 8 (DLL reset) forced to 1.
- R9: The last MRS targets the main register: `bank_sel` 00, `addr` = `mode_val` with bit 8 forced to 0.
- R10: `init_done` rises at cycle max(last MRS + `T_MRD`, DLL-reset MRS + `DLL_CYC`) and stays high. No further command follows.
- R11: A reset during the sequence drops `cke` and restarts the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock reported stable |
| mode_val | input | ADDR_W | Operating value for the main mode register |
| cke | output | 1 | Clock enable to the memory |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| bank_sel | output | BA_W | Bank address; selects the register on MRS |
| addr | output | ADDR_W | Address bus; mode-register contents on MRS |
| init_done | output | 1 | Start-up complete, reads allowed |

## Verification
The assertions assume that all timing parameters are at least 1 and that `PWRUP_CYC` and `DLL_CYC` are at least 2. They also assume that `mode_val` is constant from reset release until the final mode write. The stimulus meets these conditions:

- each run draws one random `mode_val` and holds it for the whole run;
- a run may hold `pwr_stable` low for a random delay, or pull it low once for a single cycle just before the wait would expire;
- a run may cut the sequence with a reset before or after the DLL-reset command.

// File: rtl/ddr_init_pkg.sv
// Package: shared command codes, register selectors and sequencer states
// for the DDR start-up sequencer. Assumes the memory decodes commands as
// {cs_n, ras_n, cas_n, we_n}.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    localparam logic [1:0] BANK_MAIN = 2'b00;
    localparam logic [1:0] BANK_EXT  = 2'b01;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_RST,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_MRS_RUN,
        ST_HOLD,
        ST_READY
    } init_state_e;

endpackage

// File: rtl/ddr_init_pwr_timer.sv
// Module: counts consecutive cycles in which the power-stable flag is high
// while enabled, and flags the cycle that completes the required count.
// Assumes PWRUP_CYC >= 2. A low sample or a disable clears the count.
module ddr_init_pwr_timer #(
    parameter int PWRUP_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stable,
    output logic ripe
);
    localparam int CNT_W = $clog2(PWRUP_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Completion flag: this sample is the last one the wait requires.
    assign ripe = en && stable && (cnt == LAST);

    // Count consecutive stable samples; restart on a low sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !stable) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the wait can only complete after a stable sample before this one.
    p_ripe_needs_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ripe |-> $past(stable));

endmodule

// File: rtl/ddr_init_gap_timer.sv
// Module: loadable down-counter that enforces the minimum gap after each
// command. Idle means the next command may go out in this cycle.
// Assumes the load value is gap-1 and that loads only occur while idle.
module ddr_init_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);
    logic [W-1:0] cnt;

    // Idle flag for the issuing logic.
    assign idle = (cnt == '0);

    // Load on issue, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R5: no command may be issued while a previous gap is still running.
    p_load_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(cnt) <= W'(1) || idle);

endmodule

// File: rtl/ddr_init_dll_guard.sv
// Module: tracks the cycles elapsed since the DLL-reset mode write and
// raises a sticky ok flag once DLL_CYC cycles have passed. Assumes
// DLL_CYC >= 2 and a single start pulse per reset.
module ddr_init_dll_guard #(
    parameter int DLL_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ok
);
    localparam int CNT_W = $clog2(DLL_CYC);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Count down from the DLL reset; latch ok on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
            ok    <= 1'b0;
        end else if (start) begin
            cnt   <= CNT_W'(DLL_CYC - 1);
            armed <= 1'b1;
            ok    <= 1'b0;
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                ok <= 1'b1;
            end
        end
    end

    // R10: once the DLL wait is over it stays over.
    p_ok_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ok |=> ok);

    // R10: the DLL reset happens once per start-up.
    p_single_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !armed);

endmodule

// File: rtl/ddr_init_seq.sv
// Module: top of the DDR start-up sequencer. Waits for stable power, raises
// CKE, then walks the fixed command list with enforced gaps, and signals
// completion once the DLL wait is also over. Assumes mode_val is held
// constant during the sequence and all gap parameters are >= 1.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int PWRUP_US    = 200,
    parameter int T_RP        = 3,
    parameter int T_MRD       = 2,
    parameter int T_RFC       = 9,
    parameter int DLL_CYC     = 200,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_stable,
    input  logic [ADDR_W-1:0] mode_val,
    output logic              cke,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [BA_W-1:0]   bank_sel,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int GAP_MAX   = (T_RP > T_MRD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                              : ((T_MRD > T_RFC) ? T_MRD : T_RFC);
    localparam int GAP_W     = $clog2(GAP_MAX + 1);
    localparam logic [GAP_W-1:0]  RP_LOAD  = GAP_W'(T_RP - 1);
    localparam logic [GAP_W-1:0]  MRD_LOAD = GAP_W'(T_MRD - 1);
    localparam logic [GAP_W-1:0]  RFC_LOAD = GAP_W'(T_RFC - 1);
    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;

    init_state_e       state;
    ddr_cmd_e          cmd_q;
    logic              cke_q;
    logic              done_q;
    logic [BA_W-1:0]   bank_q;
    logic [ADDR_W-1:0] addr_q;

    logic              pwr_ripe;
    logic              gap_idle;
    logic              dll_ok;
    logic              issue;
    logic              dll_start;
    ddr_cmd_e          nxt_cmd;
    logic [BA_W-1:0]   nxt_bank;
    logic [ADDR_W-1:0] nxt_addr;
    logic [GAP_W-1:0]  gap_val;
    init_state_e       nxt_state;

    ddr_init_pwr_timer #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state == ST_PWRUP),
        .stable (pwr_stable),
        .ripe   (pwr_ripe)
    );

    ddr_init_gap_timer #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue),
        .load_val (gap_val),
        .idle     (gap_idle)
    );

    ddr_init_dll_guard #(.DLL_CYC(DLL_CYC)) u_dll (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dll_start),
        .ok    (dll_ok)
    );

    // Decode the command, target and gap that belong to the current step.
    always_comb begin
        issue     = 1'b0;
        nxt_cmd   = CMD_NOP;
        nxt_bank  = '0;
        nxt_addr  = '0;
        gap_val   = '0;
        nxt_state = state;
        case (state)
            ST_PRE_A: begin
                issue = gap_idle; nxt_cmd = CMD_PRE; nxt_addr = AP_MASK;
                gap_val = RP_LOAD; nxt_state = ST_EMRS;
            end
            ST_EMRS: begin
                issue = gap_idle; nxt_cmd = CMD_MRS; nxt_bank = BA_W'(BANK_EXT);
                gap_val = MRD_LOAD; nxt_state = ST_MRS_RST;
            end
            ST_MRS_RST: begin
                issue = gap_idle; nxt_cmd = CMD_MRS; nxt_bank = BA_W'(BANK_MAIN);
                nxt_addr = mode_val | DLL_MASK;
                gap_val = MRD_LOAD; nxt_state = ST_PRE_B;
            end
            ST_PRE_B: begin
                issue = gap_idle; nxt_cmd = CMD_PRE; nxt_addr = AP_MASK;
                gap_val = RP_LOAD; nxt_state = ST_REF_A;
            end
            ST_REF_A: begin
                issue = gap_idle; nxt_cmd = CMD_REF;
                gap_val = RFC_LOAD; nxt_state = ST_REF_B;
            end
            ST_REF_B: begin
                issue = gap_idle; nxt_cmd = CMD_REF;
                gap_val = RFC_LOAD; nxt_state = ST_MRS_RUN;
            end
            ST_MRS_RUN: begin
                issue = gap_idle; nxt_cmd = CMD_MRS; nxt_bank = BA_W'(BANK_MAIN);
                nxt_addr = mode_val & ~DLL_MASK;
                gap_val = MRD_LOAD; nxt_state = ST_HOLD;
            end
            default: ;
        endcase
    end

    // The DLL wait starts with the mode write that resets the DLL.
    assign dll_start = issue && (state == ST_MRS_RST);

    // Step the sequence and register the bus; NOP whenever nothing issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_PWRUP;
            cke_q  <= 1'b0;
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            if (issue) begin
                cmd_q  <= nxt_cmd;
                bank_q <= nxt_bank;
                addr_q <= nxt_addr;
                state  <= nxt_state;
            end else if (state == ST_PWRUP && pwr_ripe) begin
                cke_q <= 1'b1;
                state <= ST_PRE_A;
            end else if (state == ST_HOLD && gap_idle && dll_ok) begin
                done_q <= 1'b1;
                state  <= ST_READY;
            end
        end
    end

    assign cke       = cke_q;
    assign cmd_cs_n  = cmd_q[3];
    assign cmd_ras_n = cmd_q[2];
    assign cmd_cas_n = cmd_q[1];
    assign cmd_we_n  = cmd_q[0];
    assign bank_sel  = bank_q;
    assign addr      = addr_q;
    assign init_done = done_q;

    // R3: no executable command while the clock enable is low.
    p_cmd_needs_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q != CMD_NOP |-> cke_q);

    // R2: the clock enable never drops outside reset.
    p_cke_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke_q |=> cke_q);

    // R6: every precharge addresses all banks.
    p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_PRE |-> (addr_q == AP_MASK && bank_q == '0));

    // R7: mode writes only target the main or extended register.
    p_mrs_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_MRS |-> (bank_q == BA_W'(BANK_MAIN) || bank_q == BA_W'(BANK_EXT)));

    // R10: completion never precedes the DLL wait.
    p_done_needs_dll_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> dll_ok);

    // R10: after completion the bus stays quiet and the flag stays high.
    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && cmd_q == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;
    import ddr_init_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 2;
    localparam int PWRUP_US   = 200;
    localparam int PWRUP_CYC  = CLK_MHZ * PWRUP_US;
    localparam int T_RP       = 3;
    localparam int T_MRD      = 2;
    localparam int T_RFC      = 9;
    localparam int DLL_CYC    = 200;
    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_stable = 1'b0;
    logic [ADDR_W-1:0] mode_val = '0;
    logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BA_W-1:0]   bank_sel;
    logic [ADDR_W-1:0] addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    ddr_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .DLL_CYC(DLL_CYC), .ADDR_W(ADDR_W), .BA_W(BA_W)
    ) u_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable), .mode_val(mode_val),
        .cke(cke), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n),
        .cmd_we_n(we_n), .bank_sel(bank_sel), .addr(addr), .init_done(init_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: one sample per edge, shortly after it.
    int              m_n;
    int              m_cyc  [16];
    logic [3:0]      m_code [16];
    logic [BA_W-1:0] m_bank [16];
    logic [ADDR_W-1:0] m_addr [16];
    int              cke_rise, done_rise, cke_cmd_bad;
    logic            cke_prev, done_prev;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_n = 0; cke_rise = -1; done_rise = -1; cke_cmd_bad = 0;
        end else begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (!cke) cke_cmd_bad++;
                if (m_n < 16) begin
                    m_cyc[m_n] = cyc; m_code[m_n] = {cs_n, ras_n, cas_n, we_n};
                    m_bank[m_n] = bank_sel; m_addr[m_n] = addr;
                end
                m_n++;
            end
            if (cke && !cke_prev) cke_rise = cyc;
            if (init_done && !done_prev) done_rise = cyc;
        end
        cke_prev = cke;
        done_prev = init_done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_code(input int i);
        case (i)
            0, 3:    return 4'b0010;
            4, 5:    return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [BA_W-1:0] exp_bank(input int i);
        return (i == 1) ? 2'b01 : 2'b00;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int i, input logic [ADDR_W-1:0] mv);
        case (i)
            0, 3:    return 13'h0400;
            2:       return mv | 13'h0100;
            6:       return mv & ~13'h0100;
            default: return '0;
        endcase
    endfunction

    function automatic int exp_gap(input int i);
        case (i)
            0, 3:    return T_RP;
            4, 5:    return T_RFC;
            default: return T_MRD;
        endcase
    endfunction

    function automatic string step_tag(input int i);
        case (i)
            1:       return "R7";
            2:       return "R8";
            6:       return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic check_reset_state();
        chk(cke == 1'b0, "R1 cke", cke, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 cmd", {cs_n, ras_n, cas_n, we_n}, 7);
        chk(init_done == 1'b0 && addr == '0 && bank_sel == '0, "R1 done/addr/bank",
            int'(addr), 0);
    endtask

    task automatic verify(input int a, input logic [ADDR_W-1:0] mv);
        int exp_done;
        chk(cke_rise == a + PWRUP_CYC, "R2 cke rise cycle", cke_rise, a + PWRUP_CYC);
        chk(m_n == 7, "R4 command count", m_n, 7);
        if (m_n >= 7) begin
            chk(m_cyc[0] == cke_rise + 1, "R4 first precharge cycle", m_cyc[0], cke_rise + 1);
            for (int i = 0; i < 7; i++) begin
                chk(m_code[i] == exp_code(i), "R4 R3 command code", m_code[i], exp_code(i));
                chk(m_bank[i] == exp_bank(i), step_tag(i), m_bank[i], exp_bank(i));
                chk(m_addr[i] == exp_addr(i, mv), step_tag(i), m_addr[i], exp_addr(i, mv));
            end
            for (int i = 1; i < 7; i++) begin
                chk(m_cyc[i] - m_cyc[i-1] == exp_gap(i-1), "R5 gap",
                    m_cyc[i] - m_cyc[i-1], exp_gap(i-1));
            end
            exp_done = (m_cyc[6] + T_MRD > m_cyc[2] + DLL_CYC) ? m_cyc[6] + T_MRD
                                                               : m_cyc[2] + DLL_CYC;
            chk(done_rise == exp_done, "R10 done cycle", done_rise, exp_done);
        end
        chk(init_done == 1'b1, "R10 done held", init_done, 1);
        chk(cke_cmd_bad == 0, "R3 command with cke low", cke_cmd_bad, 0);
    endtask

    task automatic wait_done();
        while (!init_done) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic run_one(input logic [ADDR_W-1:0] mv, input int pre_delay,
                           input bit glitch, input int glitch_at);
        int a;
        rst_n = 1'b0; pwr_stable = 1'b0; mode_val = mv;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (pre_delay) @(negedge clk);
        pwr_stable = 1'b1;
        a = cyc;
        if (glitch) begin
            repeat (glitch_at) @(negedge clk);
            pwr_stable = 1'b0;
            @(negedge clk);
            chk(cke == 1'b0, "R2 cke low before full wait", cke, 0);
            pwr_stable = 1'b1;
            a = cyc;
        end
        wait_done();
        verify(a, mv);
    endtask

    task automatic run_cut(input logic [ADDR_W-1:0] mv, input int cut);
        int a;
        rst_n = 1'b0; pwr_stable = 1'b1; mode_val = mv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (!cke) @(negedge clk);
        repeat (cut) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cke == 1'b0 && init_done == 1'b0, "R11 cke dropped on reset", cke, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R11 NOP on reset",
            {cs_n, ras_n, cas_n, we_n}, 7);
        rst_n = 1'b1;
        a = cyc;
        wait_done();
        verify(a, mv);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);
        run_one(13'h0000, 0, 1'b0, 0);
        run_one(13'h1FFF, 5, 1'b1, PWRUP_CYC - 1);
        for (int k = 0; k < 4; k++) begin
            run_one(ADDR_W'($urandom()), int'($urandom_range(0, 30)),
                    1'($urandom_range(0, 1)), int'($urandom_range(1, PWRUP_CYC - 1)));
        end
        run_cut(ADDR_W'($urandom()), 1);
        run_cut(ADDR_W'($urandom()), 15);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule